// File: doc/BRIEF.md
# Configurable External Interrupt Detector

This block turns a set of asynchronous external interrupt pins into request-set signals for a downstream priority resolver. Each channel has a sense bit (edge or level) and a polarity bit. The polarity bit has a crossed meaning. With polarity clear, a channel fires on a high level, or on a high-to-low transition. With polarity set, it fires on a low level, or on a low-to-high transition.

One channel, chosen by a parameter, can take its source from a group of key-scan inputs instead of its own pin. The key inputs are combined by OR after polarity handling. A two-bit source field selects the dedicated pin, the narrow key group or the full key group. One code of that field is reserved and silences the channel.

The highest-numbered channel has write-protected configuration, which changes only while a separate unlock input is high. Every pin and key passes through a synchronizer before detection. Software programs each channel through a simple write port.

Top module: `eirq_detector`

## Requirements
- R1: After reset every channel is in edge sense with polarity 0 and pin source, and req_set is all zero.
- R2: A pin or key change reaches req_set after two rising clock edges. The output is unchanged after the first edge and follows the change after the second.
- R3: In level sense (cfg_wr_data[1]=1) with polarity 0 (cfg_wr_data[0]=0), the request is high in every cycle that the synchronized pin is high.
- R4: In level sense with polarity 1, the request is high in every cycle that the synchronized pin is low.
- R5: In edge sense (cfg_wr_data[1]=0) with polarity 0, a high-to-low pin transition gives a request pulse of exactly one cycle. A low-to-high transition gives none.
- R6: In edge sense with polarity 1, a low-to-high transition gives a one-cycle pulse. A high-to-low transition gives none.
- R7: On the key channel, source field cfg_wr_data[3:2]=10 makes the source the OR of keys 0 to 3. Each key counts as active when high under polarity 0 and when low under polarity 1. Key 4 and the dedicated pin then have no effect.
- R8: Source field 11 makes the source the OR of keys 0 to 4, with the same per-key polarity.
- R9: In key mode, edge sense gives a one-cycle pulse when the combined source goes from inactive to active. Level sense requests in every cycle that it is active.
- R10: Source field 01 is reserved. The key channel then produces no requests in either sense.
- R11: On every channel other than the key channel, the source field has no effect.
- R12: A write to the highest channel (index N_CH-1) is ignored while cfg_unlock is 0, and takes effect while cfg_unlock is 1.
- R13: In the cycle right after a write to a channel, that channel produces no edge-sense request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_pin | input | N_CH | Asynchronous external interrupt pins |
| key_in | input | N_KEY | Asynchronous key-scan inputs |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_sel | input | SEL_W | Channel index of the write |
| cfg_wr_data | input | 4 | [3:2] source field, [1] sense (1 = level), [0] polarity |
| cfg_unlock | input | 1 | Allows writes to the highest channel |
| req_set | output | N_CH | Request-set output per channel |

## Verification
The assertions assume that a channel's sense, polarity and source change only through the write port. They also assume that cfg_unlock is a level that is already valid in the cycle of the write. The one-shot and post-write properties rely on the mute cycle that follows every write, so the bench never expects an edge request in that cycle. All pins, keys and writes are driven at the falling clock edge, so each change is captured by exactly one rising edge. After every write, the inputs are given several quiet cycles before the next transition that is measured.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
   // Source field codes of the key-capable channel
   typedef enum logic [1:0] {
      SRC_PIN      = 2'b00,
      SRC_RESERVED = 2'b01,
      SRC_KEY_LO   = 2'b10,
      SRC_KEY_ALL  = 2'b11
   } src_sel_e;

   // Bit positions inside the configuration write word
   localparam int unsigned CFG_POL_BIT   = 0;
   localparam int unsigned CFG_SENSE_BIT = 1;
   localparam int unsigned CFG_SRC_LSB   = 2;
   localparam int unsigned CFG_W         = 4;
endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
   parameter int unsigned W      = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2 || STAGES > 3) begin : g_bad_stages
      $error("eirq_sync: STAGES must be 2 or 3");
   end

   logic [W-1:0] stg_q [STAGES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
      end else begin
         stg_q[0] <= d;
         for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
      end
   end

   assign q = stg_q[STAGES-1];

   // Cycles since reset, saturating at the chain depth (checker support)
   logic [1:0] age_q;
   always_ff @(posedge clk) begin
      if (!rst_n)                    age_q <= '0;
      else if (age_q != 2'(STAGES))  age_q <= age_q + 2'd1;
   end

   AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q == 2'(STAGES)) |-> (q == $past(d, STAGES))); // R2
endmodule

// File: rtl/eirq_cfg_regs.sv
module eirq_cfg_regs
   import eirq_pkg::*;
#(
   parameter int unsigned N_CH   = 5,
   parameter int unsigned KEY_CH = 3,
   parameter int unsigned SEL_W  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [SEL_W-1:0] wr_sel,
   input  logic [CFG_W-1:0] wr_data,
   input  logic             unlock,
   output logic [N_CH-1:0]  level_o,
   output logic [N_CH-1:0]  pol_o,
   output logic [1:0]       key_sel_o,
   output logic [N_CH-1:0]  hit_o
);
   localparam int unsigned LOCK_CH = N_CH - 1;

   logic [N_CH-1:0] level_q;
   logic [N_CH-1:0] pol_q;
   logic [1:0]      key_sel_q;

   for (genvar i = 0; i < N_CH; i++) begin : g_hit
      if (i == LOCK_CH) begin : g_locked
         assign hit_o[i] = wr_en && (wr_sel == SEL_W'(i)) && unlock;
      end else begin : g_open
         assign hit_o[i] = wr_en && (wr_sel == SEL_W'(i));
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         level_q   <= '0;
         pol_q     <= '0;
         key_sel_q <= SRC_PIN;
      end else begin
         for (int i = 0; i < N_CH; i++) begin
            if (hit_o[i]) begin
               level_q[i] <= wr_data[CFG_SENSE_BIT];
               pol_q[i]   <= wr_data[CFG_POL_BIT];
            end
         end
         if (hit_o[KEY_CH]) key_sel_q <= wr_data[CFG_SRC_LSB +: 2];
      end
   end

   assign level_o   = level_q;
   assign pol_o     = pol_q;
   assign key_sel_o = key_sel_q;

   AST_LOCK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_sel == SEL_W'(LOCK_CH)) && !unlock)
      |=> ($stable(level_q[LOCK_CH]) && $stable(pol_q[LOCK_CH]))); // R12
endmodule

// File: rtl/eirq_keymux.sv
module eirq_keymux
   import eirq_pkg::*;
#(
   parameter int unsigned N_KEY      = 5,
   parameter int unsigned KEY_NARROW = 4
) (
   input  logic [N_KEY-1:0] keys_s,
   input  logic             pol_low,
   input  logic [1:0]       key_sel,
   output logic             use_keys,
   output logic             src_off,
   output logic             key_any
);
   if (KEY_NARROW == 0 || KEY_NARROW >= N_KEY) begin : g_bad_narrow
      $error("eirq_keymux: KEY_NARROW must be between 1 and N_KEY-1");
   end

   logic [N_KEY-1:0] key_act;
   logic [N_KEY-1:0] key_mask;

   assign key_act = pol_low ? ~keys_s : keys_s;

   for (genvar k = 0; k < N_KEY; k++) begin : g_mask
      if (k < KEY_NARROW) begin : g_always
         assign key_mask[k] = 1'b1;
      end else begin : g_wide
         assign key_mask[k] = (key_sel == SRC_KEY_ALL);
      end
   end

   assign use_keys = key_sel[1];
   assign src_off  = (key_sel == SRC_RESERVED);
   assign key_any  = |(key_act & key_mask);
endmodule

// File: rtl/eirq_chan.sv
module eirq_chan (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_s,
   input  logic level_mode,
   input  logic pol_low,
   input  logic use_alt,
   input  logic src_off,
   input  logic alt_act,
   input  logic cfg_hit,
   output logic req
);
   logic pin_act;
   logic act;
   logic act_q;
   logic mute_q;
   logic edge_hit;

   // Polarity folds both senses onto one "active" signal:
   // pin edges then always show up as active falling.
   assign pin_act  = pol_low ? ~pin_s : pin_s;
   assign act      = use_alt ? alt_act : pin_act;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         mute_q <= 1'b0;
      end else begin
         act_q  <= act;
         mute_q <= cfg_hit;
      end
   end

   assign edge_hit = use_alt ? (act & ~act_q) : (act_q & ~act);
   assign req      = ~src_off & (level_mode ? act : (edge_hit & ~mute_q));

   AST_EDGE_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !level_mode) |=> (!req || level_mode)); // R5
   AST_MUTE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cfg_hit) && !level_mode) |-> !req); // R13
endmodule

// File: rtl/eirq_detector.sv
module eirq_detector
   import eirq_pkg::*;
#(
   parameter int unsigned N_CH        = 5,
   parameter int unsigned KEY_CH      = 3,
   parameter int unsigned N_KEY       = 5,
   parameter int unsigned KEY_NARROW  = 4,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned SEL_W      = (N_CH > 1) ? $clog2(N_CH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_CH-1:0]  irq_pin,
   input  logic [N_KEY-1:0] key_in,
   input  logic             cfg_wr_en,
   input  logic [SEL_W-1:0] cfg_wr_sel,
   input  logic [CFG_W-1:0] cfg_wr_data,
   input  logic             cfg_unlock,
   output logic [N_CH-1:0]  req_set
);
   if (N_CH < 2)       begin : g_bad_nch  $error("eirq_detector: N_CH must be at least 2");  end
   if (KEY_CH >= N_CH) begin : g_bad_kch  $error("eirq_detector: KEY_CH out of range");      end

   logic [N_CH-1:0]  pin_s;
   logic [N_KEY-1:0] keys_s;
   logic [N_CH-1:0]  level_v;
   logic [N_CH-1:0]  pol_v;
   logic [N_CH-1:0]  hit_v;
   logic [1:0]       key_sel;

   eirq_sync #(.W(N_CH), .STAGES(SYNC_STAGES)) u_pin_sync (
      .clk(clk), .rst_n(rst_n), .d(irq_pin), .q(pin_s));

   eirq_sync #(.W(N_KEY), .STAGES(SYNC_STAGES)) u_key_sync (
      .clk(clk), .rst_n(rst_n), .d(key_in), .q(keys_s));

   eirq_cfg_regs #(.N_CH(N_CH), .KEY_CH(KEY_CH), .SEL_W(SEL_W)) u_cfg (
      .clk(clk), .rst_n(rst_n),
      .wr_en(cfg_wr_en), .wr_sel(cfg_wr_sel), .wr_data(cfg_wr_data),
      .unlock(cfg_unlock),
      .level_o(level_v), .pol_o(pol_v), .key_sel_o(key_sel), .hit_o(hit_v));

   for (genvar i = 0; i < N_CH; i++) begin : g_ch
      if (i == KEY_CH) begin : g_keyed
         logic use_keys;
         logic src_off;
         logic key_any;

         eirq_keymux #(.N_KEY(N_KEY), .KEY_NARROW(KEY_NARROW)) u_keymux (
            .keys_s(keys_s), .pol_low(pol_v[i]), .key_sel(key_sel),
            .use_keys(use_keys), .src_off(src_off), .key_any(key_any));

         eirq_chan u_chan (
            .clk(clk), .rst_n(rst_n), .pin_s(pin_s[i]),
            .level_mode(level_v[i]), .pol_low(pol_v[i]),
            .use_alt(use_keys), .src_off(src_off), .alt_act(key_any),
            .cfg_hit(hit_v[i]), .req(req_set[i]));
      end else begin : g_plain
         eirq_chan u_chan (
            .clk(clk), .rst_n(rst_n), .pin_s(pin_s[i]),
            .level_mode(level_v[i]), .pol_low(pol_v[i]),
            .use_alt(1'b0), .src_off(1'b0), .alt_act(1'b0),
            .cfg_hit(hit_v[i]), .req(req_set[i]));
      end
   end

   AST_RESERVED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (key_sel == SRC_RESERVED) |-> !req_set[KEY_CH]); // R10
endmodule

// File: tb/eirq_detector_tb.sv
`timescale 1ns/1ps
module eirq_detector_tb;
   localparam int N_CH = 5;
   localparam int N_KEY = 5;
   localparam int KEY_CH = 3;
   localparam int LOCK_CH = N_CH - 1;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [N_CH-1:0]  irq_pin = '0;
   logic [N_KEY-1:0] key_in = '0;
   logic             cfg_wr_en = 1'b0;
   logic [2:0]       cfg_wr_sel = '0;
   logic [3:0]       cfg_wr_data = '0;
   logic             cfg_unlock = 1'b0;
   logic [N_CH-1:0]  req_set;

   int  checks = 0;
   int  errors = 0;
   bit  done = 1'b0;

   always #2.5 clk = ~clk;

   eirq_detector u_dut (
      .clk(clk), .rst_n(rst_n), .irq_pin(irq_pin), .key_in(key_in),
      .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel), .cfg_wr_data(cfg_wr_data),
      .cfg_unlock(cfg_unlock), .req_set(req_set));

   // {cfg[3:0], pin_before, pin_after, exp_after1, exp_after2, exp_after3}
   localparam int NVEC = 10;
   localparam logic [8:0] VEC [NVEC] = '{
      {4'h0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
      {4'h0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
      {4'h1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
      {4'h1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
      {4'h2, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1},
      {4'h2, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
      {4'h3, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1},
      {4'h3, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
      {4'hC, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
      {4'hE, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1}
   };

   function automatic string vec_tag(input logic [3:0] c);
      if (c[3:2] != 2'b00) return "R11";
      case (c[1:0])
         2'b00:   return "R5";
         2'b01:   return "R6";
         2'b10:   return "R3";
         default: return "R4";
      endcase
   endfunction

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic cfg_write(input int ch, input logic [3:0] data);
      cfg_wr_en   = 1'b1;
      cfg_wr_sel  = 3'(ch);
      cfg_wr_data = data;
      tick(1);
      cfg_wr_en   = 1'b0;
   endtask

   initial begin
      #(5.0 * 100000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      tick(4);
      rst_n = 1'b1;
      tick(1);
      // R1: reset state and default edge/polarity-0 behaviour
      check("R1", |req_set, 1'b0);
      irq_pin[1] = 1'b1; tick(4);
      check("R1", req_set[1], 1'b0);
      irq_pin[1] = 1'b0; tick(2);
      check("R1", req_set[1], 1'b1);
      tick(1);
      check("R1", req_set[1], 1'b0);

      // Table walk on channel 0
      for (int v = 0; v < NVEC; v++) begin
         logic [3:0] c;
         c = VEC[v][8:5];
         cfg_write(0, c);
         irq_pin[0] = VEC[v][4];
         tick(4);
         irq_pin[0] = VEC[v][3];
         tick(1); check("R2", req_set[0], VEC[v][2]);
         tick(1); check(vec_tag(c), req_set[0], VEC[v][1]);
         tick(1); check(vec_tag(c), req_set[0], VEC[v][0]);
      end

      // R13: polarity flip with pin held high must not fake an edge
      cfg_write(0, 4'h0);
      irq_pin[0] = 1'b1; tick(4);
      cfg_write(0, 4'h1);
      check("R13", req_set[0], 1'b0);
      tick(1);
      check("R13", req_set[0], 1'b0);

      // R7: narrow key group, edge, polarity 0
      key_in = '0; irq_pin[KEY_CH] = 1'b0;
      cfg_write(KEY_CH, 4'h8); tick(3);
      key_in[4] = 1'b1; tick(2);
      check("R7", req_set[KEY_CH], 1'b0);
      tick(1);
      check("R7", req_set[KEY_CH], 1'b0);
      irq_pin[KEY_CH] = 1'b1; tick(3);
      irq_pin[KEY_CH] = 1'b0; tick(2);
      check("R7", req_set[KEY_CH], 1'b0);
      tick(1);
      key_in[2] = 1'b1; tick(2);
      check("R9", req_set[KEY_CH], 1'b1);
      tick(1);
      check("R9", req_set[KEY_CH], 1'b0);
      key_in = '0; tick(3);

      // R8: full key group, key 4 alone triggers
      cfg_write(KEY_CH, 4'hC); tick(3);
      key_in[4] = 1'b1; tick(2);
      check("R8", req_set[KEY_CH], 1'b1);
      tick(1);
      check("R8", req_set[KEY_CH], 1'b0);

      // R9: full key group, level, polarity 1 (keys active low)
      key_in = 5'h1F;
      cfg_write(KEY_CH, 4'hF); tick(3);
      check("R9", req_set[KEY_CH], 1'b0);
      key_in[1] = 1'b0; tick(2);
      check("R9", req_set[KEY_CH], 1'b1);
      tick(3);
      check("R9", req_set[KEY_CH], 1'b1);
      key_in[1] = 1'b1; tick(2);
      check("R9", req_set[KEY_CH], 1'b0);

      // R10: reserved source code, level polarity 0 with pin and keys high
      irq_pin[KEY_CH] = 1'b1;
      cfg_write(KEY_CH, 4'h6); tick(3);
      check("R10", req_set[KEY_CH], 1'b0);
      tick(2);
      check("R10", req_set[KEY_CH], 1'b0);
      key_in = '0; irq_pin[KEY_CH] = 1'b0; tick(3);

      // R12: locked channel ignores writes until unlocked
      irq_pin[LOCK_CH] = 1'b1; tick(3);
      cfg_write(LOCK_CH, 4'h2);
      check("R12", req_set[LOCK_CH], 1'b0);
      tick(2);
      check("R12", req_set[LOCK_CH], 1'b0);
      cfg_unlock = 1'b1;
      cfg_write(LOCK_CH, 4'h2);
      cfg_unlock = 1'b0;
      check("R12", req_set[LOCK_CH], 1'b1);
      tick(2);
      check("R12", req_set[LOCK_CH], 1'b1);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule